// File: doc/BRIEF.md
# Three-Wire Serial Clock-Calendar Target

This block is the target end of a three-wire serial link to a clock-calendar. The host drives the link by writing an 8-bit port value. Each write carries the data, clock and chip-select levels, a data-direction bit, and separate write enables for the clock and chip-select lines. When the host reads the port back, it sees its last written value. While a read transfer is running, bit 0 of that value is replaced by the bit the block is shifting out.

A transfer begins with a start condition. The block then takes in a seven-bit command and a direction bit. After that it either sends out a register or calendar image, or captures a data byte into a register. The block holds two status bytes, a clock-adjustment byte and a general-purpose byte. The calendar values come from an input time bundle in binary form, and the block converts them to BCD on the way out.

Top module: `rtc3w_slave`

## Requirements
- R1: Port bits: [0] data, [1] clock, [2] chip select, [4] direction (1 = host drives data), [5] clock enable, [6] select enable. Clock or select keeps its old level when its enable is 0. Data keeps its old level when direction is 0.
- R2: A transfer starts only when the previous line state has select low and clock high, and the new state has both high.
- R3: Command bits are taken least significant first, one per falling clock edge. Bits 1 and 2 must both be 1, otherwise the block goes idle. Bits 6:4 form the command index, so the command byte is {dir, index[2:0], 4'b0110}.
- R4: Select going low during the command or direction phase returns the block to idle.
- R5: The eighth bit, sampled on a falling edge, sets the direction: 1 = block sends, 0 = block receives.
- R6: Transfer lengths for indices 0..7 are 8, 8, 56, 24, L4, 24, 8, 8 bits. L4 is 24 when status byte 2 bits [3:0] equal 4, and 8 otherwise. After the last bit the block is idle.
- R7: Status byte 1 resets to 0x02. Reading it (index 0) returns its value and then clears bit 7.
- R8: Writing index 0 sets status byte 1 to (old & 0xF1) | data | 0x0E.
- R9: Index 1 (status byte 2), index 6 (adjustment) and index 7 (general byte) read back the last byte written to them. All reset to 0x00.
- R10: Index 2 returns seven bytes, first to last:
  - BCD year
  - BCD month
  - BCD day
  - (weekday + 6) mod 8
  - BCD hour (24-hour)
  - BCD minute
  - BCD second
- R11: Index 3 returns BCD hour, minute and second.
- R12: Indices 4 and 5 return all-zero bits, and writes to them change nothing.
- R13: Port read bits [7:1] equal the last written port value. Bit 0 equals the written bit 0, except after a falling edge in a read transfer, when it holds the bit just sent until the next port write. The read value is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host port write strobe |
| wr_data_i | input | 8 | Host port write value |
| rd_data_o | output | 8 | Host port read value |
| year_i | input | 7 | Year within century, binary 0..99 |
| month_i | input | 4 | Month, binary 1..12 |
| day_i | input | 5 | Day of month, binary 1..31 |
| wday_i | input | 3 | Weekday, binary 0..6 |
| hour_i | input | 5 | Hour, binary 0..23 |
| min_i | input | 6 | Minute, binary 0..59 |
| sec_i | input | 6 | Second, binary 0..59 |

## Verification
The assertions assume that all line activity arrives through port writes, one per strobe. They also assume that the time bundle holds in-range binary values whenever a calendar image is captured. The stimulus meets both assumptions: every line change is a complete port write with the enables set, and the time bundle is only changed while the block is idle. The stimulus also covers the edge cases of the protocol:
- a line held by a cleared enable
- a select that rises while the clock is low
- a bad command code
- a select that drops partway through a command
- the two lengths of index 4

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int IMG_BYTES = 7;
  localparam int IMG_W     = IMG_BYTES * 8;
  localparam int CNT_W     = $clog2(IMG_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DIR, ST_WR, ST_RD
  } st_e;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [CNT_W-1:0] xfer_len(input logic [2:0] idx,
                                                input logic [3:0] s2_lo);
    case (idx)
      3'd2:      return CNT_W'(56);
      3'd3,
      3'd5:      return CNT_W'(24);
      3'd4:      return (s2_lo == 4'd4) ? CNT_W'(24) : CNT_W'(8);
      default:   return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/rtc3w_lines.sv
module rtc3w_lines (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic       sio_o,
  output logic       cs_o,
  output logic       cs_q_o,
  output logic       start_o,
  output logic       fall_o,
  output logic [7:0] port_q_o
);
  logic sio_q, sck_q, cs_q;
  logic sio_n, sck_n, cs_n;

  assign sio_n = wr_data_i[4] ? wr_data_i[0] : sio_q;
  assign sck_n = wr_data_i[5] ? wr_data_i[1] : sck_q;
  assign cs_n  = wr_data_i[6] ? wr_data_i[2] : cs_q;

  assign sio_o   = sio_n;
  assign cs_o    = cs_n;
  assign cs_q_o  = cs_q;
  assign start_o = wr_valid_i & ~cs_q & sck_q & cs_n & sck_n;
  assign fall_o  = wr_valid_i & sck_q & ~sck_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sio_q    <= 1'b0;
      sck_q    <= 1'b0;
      cs_q     <= 1'b0;
      port_q_o <= '0;
    end else if (wr_valid_i) begin
      sio_q    <= sio_n;
      sck_q    <= sck_n;
      cs_q     <= cs_n;
      port_q_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/rtc3w_image.sv
module rtc3w_image
  import rtc3w_pkg::*;
(
  input  logic [2:0]       idx_i,
  input  logic [7:0]       s1_i,
  input  logic [7:0]       s2_i,
  input  logic [7:0]       adj_i,
  input  logic [7:0]       gp_i,
  input  logic [6:0]       year_i,
  input  logic [3:0]       month_i,
  input  logic [4:0]       day_i,
  input  logic [2:0]       wday_i,
  input  logic [4:0]       hour_i,
  input  logic [5:0]       min_i,
  input  logic [5:0]       sec_i,
  output logic [IMG_W-1:0] img_o
);
  logic [7:0] b_year, b_mon, b_day, b_wd, b_hour, b_min, b_sec;

  assign b_year = to_bcd(year_i);
  assign b_mon  = to_bcd({3'd0, month_i});
  assign b_day  = to_bcd({2'd0, day_i});
  assign b_wd   = {5'd0, wday_i + 3'd6};
  assign b_hour = to_bcd({2'd0, hour_i});
  assign b_min  = to_bcd({1'b0, min_i});
  assign b_sec  = to_bcd({1'b0, sec_i});

  // byte 0 sits in bits [7:0] and leaves first
  always_comb begin
    img_o = '0;
    case (idx_i)
      3'd0: img_o[7:0]  = s1_i;
      3'd1: img_o[7:0]  = s2_i;
      3'd2: img_o       = {b_sec, b_min, b_hour, b_wd, b_day, b_mon, b_year};
      3'd3: img_o[23:0] = {b_sec, b_min, b_hour};
      3'd6: img_o[7:0]  = adj_i;
      3'd7: img_o[7:0]  = gp_i;
      default: img_o    = '0;
    endcase
  end
endmodule

// File: rtl/rtc3w_regs.sv
module rtc3w_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_load_i,
  input  logic       commit_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] s1_o,
  output logic [7:0] s2_o,
  output logic [7:0] adj_o,
  output logic [7:0] gp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_o  <= 8'h02;
      s2_o  <= 8'h00;
      adj_o <= 8'h00;
      gp_o  <= 8'h00;
    end else if (rd_load_i) begin
      if (idx_i == 3'd0) s1_o <= s1_o & 8'h7F;
    end else if (commit_i) begin
      case (idx_i)
        3'd0: s1_o  <= (s1_o & 8'hF1) | wbyte_i | 8'h0E;
        3'd1: s2_o  <= wbyte_i;
        3'd6: adj_o <= wbyte_i;
        3'd7: gp_o  <= wbyte_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_slave.sv
module rtc3w_slave
  import rtc3w_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic [6:0] year_i,
  input  logic [3:0] month_i,
  input  logic [4:0] day_i,
  input  logic [2:0] wday_i,
  input  logic [4:0] hour_i,
  input  logic [5:0] min_i,
  input  logic [5:0] sec_i
);
  st_e              state_q;
  logic [CNT_W-1:0] cnt_q, len_q;
  logic [2:0]       idx_q;
  logic             ok_q;
  logic [IMG_W-1:0] buf_q, img;
  logic             out_bit_q, drive_q;
  logic             sio_n, cs_n, cs_q, start, fall;
  logic [7:0]       port_q;
  logic [7:0]       s1, s2, adj, gp, wbyte;
  logic             rd_load, commit, last;

  rtc3w_lines u_lines (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i,
    .sio_o(sio_n), .cs_o(cs_n), .cs_q_o(cs_q),
    .start_o(start), .fall_o(fall), .port_q_o(port_q)
  );

  rtc3w_image u_image (
    .idx_i(idx_q), .s1_i(s1), .s2_i(s2), .adj_i(adj), .gp_i(gp),
    .year_i, .month_i, .day_i, .wday_i, .hour_i, .min_i, .sec_i,
    .img_o(img)
  );

  assign last    = (cnt_q == len_q - CNT_W'(1));
  assign rd_load = fall & cs_n & sio_n & (state_q == ST_DIR);
  assign commit  = fall & last & (state_q == ST_WR);
  assign wbyte   = (cnt_q == CNT_W'(7)) ? {sio_n, buf_q[6:0]} : buf_q[7:0];

  rtc3w_regs u_regs (
    .clk_i, .rst_ni, .rd_load_i(rd_load), .commit_i(commit),
    .idx_i(idx_q), .wbyte_i(wbyte),
    .s1_o(s1), .s2_o(s2), .adj_o(adj), .gp_o(gp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      len_q     <= CNT_W'(8);
      idx_q     <= '0;
      ok_q      <= 1'b0;
      buf_q     <= '0;
      out_bit_q <= 1'b0;
      drive_q   <= 1'b0;
    end else if (wr_valid_i) begin
      drive_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_CMD;
          cnt_q   <= '0;
          idx_q   <= '0;
          ok_q    <= 1'b1;
        end
        ST_CMD: if (!cs_n) begin
          state_q <= ST_IDLE;
        end else if (fall) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(1) || cnt_q == CNT_W'(2)) ok_q <= ok_q & sio_n;
          if (cnt_q == CNT_W'(4)) idx_q[0] <= sio_n;
          if (cnt_q == CNT_W'(5)) idx_q[1] <= sio_n;
          if (cnt_q == CNT_W'(6)) begin
            idx_q[2] <= sio_n;
            state_q  <= ok_q ? ST_DIR : ST_IDLE;
          end
        end
        ST_DIR: if (!cs_n) begin
          state_q <= ST_IDLE;
        end else if (fall) begin
          cnt_q <= '0;
          len_q <= xfer_len(idx_q, s2[3:0]);
          if (sio_n) begin
            state_q <= ST_RD;
            buf_q   <= img;
          end else begin
            state_q <= ST_WR;
            buf_q   <= '0;
          end
        end
        ST_WR: if (fall) begin
          buf_q[cnt_q] <= sio_n;
          cnt_q        <= cnt_q + CNT_W'(1);
          if (last) state_q <= ST_IDLE;
        end
        ST_RD: if (fall) begin
          out_bit_q <= buf_q[cnt_q];
          drive_q   <= 1'b1;
          cnt_q     <= cnt_q + CNT_W'(1);
          if (last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_data_o = {port_q[7:1], drive_q ? out_bit_q : port_q[0]};
endmodule

// File: rtl/rtc3w_checks.sv
module rtc3w_checks
  import rtc3w_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       rd_data_o,
  input st_e              state_q,
  input logic             cs_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] len_q,
  input logic             rd_load,
  input logic             commit,
  input logic [2:0]       idx_q,
  input logic [7:0]       wbyte,
  input logic [7:0]       s1,
  input logic [7:0]       adj
);
  a_r4_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) && ($past(state_q) == ST_CMD || $past(state_q) == ST_DIR)
      |-> state_q == ST_IDLE);

  a_r6_cnt_in_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR || state_q == ST_RD) |-> cnt_q < len_q);

  a_r7_clear_b7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load && idx_q == 3'd0 |=> !s1[7]);

  a_r8_mode_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1[1]);

  a_r9_adj_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && idx_q == 3'd6 |=> adj == $past(wbyte));

  a_r13_port_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> rd_data_o[7:1] == $past(wr_data_i[7:1]));
endmodule

bind rtc3w_slave rtc3w_checks u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .state_q(state_q),
  .cs_q(cs_q), .cnt_q(cnt_q), .len_q(len_q), .rd_load(rd_load),
  .commit(commit), .idx_q(idx_q), .wbyte(wbyte), .s1(s1), .adj(adj)
);

// File: tb/rtc3w_slave_bench.sv
`timescale 1ns/1ps
module rtc3w_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [6:0] year = 7'd9;
  logic [3:0] month = 4'd1;
  logic [4:0] day = 5'd20;
  logic [2:0] wday = 3'd2;
  logic [4:0] hour = 5'd21;
  logic [5:0] minute = 6'd31;
  logic [5:0] second = 6'd32;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc3w_slave u_rtc3w_slave (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .year_i(year), .month_i(month), .day_i(day),
    .wday_i(wday), .hour_i(hour), .min_i(minute), .sec_i(second)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] pv(input logic cs, input logic sck,
                                    input logic sio, input logic dd);
    return {1'b0, 1'b1, 1'b1, dd, 1'b0, cs, sck, sio};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one port write; model of the read-back: port echo, bit 0 from drv/b
  task automatic pw(input logic [7:0] v, input logic drv, input logic b, input string req);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = v;
    @(negedge clk);
    wr_valid = 1'b0;
    check(rd_data, drv ? {v[7:1], b} : v, req);
  endtask

  task automatic start_x();
    pw(pv(0, 1, 0, 0), 0, 0, "R13 idle");
    pw(pv(1, 1, 0, 0), 0, 0, "R2 start");
  endtask

  task automatic end_x();
    pw(pv(0, 1, 0, 0), 0, 0, "R13 end");
  endtask

  task automatic send_bit(input logic b, input string req);
    pw(pv(1, 0, b, 1), 0, 0, req);
    pw(pv(1, 1, b, 1), 0, 0, req);
  endtask

  task automatic send_cmd(input logic [2:0] idx, input logic dir, input logic [3:0] code);
    logic [7:0] c;
    c = {dir, idx, code};
    for (int i = 0; i < 8; i++) send_bit(c[i], "R5 cmd");
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [23:0] d, input int n);
    start_x();
    send_cmd(idx, 1'b0, 4'b0110);
    for (int i = 0; i < n; i++) send_bit(d[i], "R5 write phase");
    end_x();
  endtask

  // n falling edges; the first len drive a bit, the rest echo port bit 0 (=1)
  task automatic rd_reg(input logic [2:0] idx, input logic [55:0] e, input int len,
                        input int n, input string req);
    start_x();
    send_cmd(idx, 1'b1, 4'b0110);
    for (int i = 0; i < n; i++) begin
      pw(pv(1, 0, 1, 0), i < len, e[i], req);
      pw(pv(1, 1, 1, 0), 0, 0, req);
    end
    end_x();
  endtask

  function automatic logic [55:0] date_img();
    return {bcd(second), bcd(minute), bcd(hour), 8'((wday + 6) % 8),
            bcd(day), bcd(month), bcd(year)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 8'h00, "R13 reset value");
    rst_n = 1'b1;
    rd_reg(3'd0, 56'h02, 8, 8, "R7 reset status1");

    wr_reg(3'd7, 24'hA5, 8);
    rd_reg(3'd7, 56'hA5, 8, 9, "R9 free byte");
    wr_reg(3'd6, 24'h3C, 8);
    rd_reg(3'd6, 56'h3C, 8, 8, "R9 adjust byte");
    wr_reg(3'd1, 24'h17, 8);
    rd_reg(3'd1, 56'h17, 8, 9, "R9 status2");

    wr_reg(3'd0, 24'h81, 8);
    rd_reg(3'd0, 56'h8F, 8, 8, "R8 status1 write mask");
    rd_reg(3'd0, 56'h0F, 8, 8, "R7 status1 bit7 cleared");

    rd_reg(3'd2, date_img(), 56, 57, "R10 date image A");
    year = 7'd99; month = 4'd12; day = 5'd31; wday = 3'd6;
    hour = 5'd0; minute = 6'd59; second = 6'd7;
    rd_reg(3'd2, date_img(), 56, 57, "R10 date image B");
    hour = 5'd13; minute = 6'd5; second = 6'd40;
    rd_reg(3'd3, {32'd0, bcd(second), bcd(minute), bcd(hour)}, 24, 25, "R11 time image");

    wr_reg(3'd5, 24'hFFFFFF, 24);
    rd_reg(3'd5, 56'h0, 24, 25, "R12 index5 zeros");
    wr_reg(3'd1, 24'h04, 8);
    rd_reg(3'd4, 56'h0, 24, 25, "R6 index4 long");
    wr_reg(3'd4, 24'hFFFFFF, 24);
    rd_reg(3'd1, 56'h04, 8, 8, "R12 index4 write ignored");
    wr_reg(3'd1, 24'h00, 8);
    rd_reg(3'd4, 56'h0, 8, 9, "R6 index4 short");

    // R4: select dropped during the command phase
    start_x();
    send_bit(1'b0, "R4 partial"); send_bit(1'b1, "R4 partial"); send_bit(1'b1, "R4 partial");
    pw(pv(0, 1, 0, 1), 0, 0, "R4 drop select");
    send_bit(1'b0, "R4 rest"); send_cmd(3'd7, 1'b0, 4'b0110);
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R4 rest");
    end_x();
    rd_reg(3'd7, 56'hA5, 8, 8, "R4 abort kept free byte");

    // R3: bad code
    start_x();
    send_cmd(3'd7, 1'b0, 4'b0000);
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R3 bad code data");
    end_x();
    rd_reg(3'd7, 56'hA5, 8, 8, "R3 bad code ignored");

    // R2: select rises while clock low -> no start
    pw(pv(0, 0, 0, 0), 0, 0, "R2 low clock");
    pw(pv(1, 0, 0, 0), 0, 0, "R2 no start");
    send_cmd(3'd7, 1'b0, 4'b0110);
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R2 data");
    end_x();
    rd_reg(3'd7, 56'hA5, 8, 8, "R2 no transfer");

    // R1: clock held by cleared enable gives no edge mid-read
    start_x();
    send_cmd(3'd7, 1'b1, 4'b0110);
    for (int i = 0; i < 8; i++) begin
      pw(pv(1, 0, 1, 0), 1, i == 0 || i == 2 || i == 5 || i == 7, "R1 read");
      pw(8'b0000_0101, 0, 0, "R1 held lines");
      pw(pv(1, 1, 1, 0), 0, 0, "R1 read");
    end
    end_x();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule